// File: doc/BRIEF.md
# Direct-Address Operand Matching Unit

This block joins the two operands of a dataflow instruction without any associative search or hashing. Every arriving token names an operand-segment base and an offset. The unit turns these into one absolute word address in an ordinary synchronous RAM, called the matching store. It reads that word and looks at its presence flag. If the partner is already waiting, the unit clears the flag and emits both operands. If not, it writes the new operand with the flag set, and the token then waits for its partner.

Before matching, the unit reads the word at the segment base. The low bits of that word hold the number of the template segment (the code) bound to this function invocation. The offset passes through unchanged as the instruction offset inside that template. Some tokens need no matching store access:
- A token whose partner is an immediate constant reads the word at its match address and uses it without changing it.
- A token for a single-operand instruction skips matching altogether.
- A special (non-data) token skips both the template fetch and matching.

The unit accepts one token at a time through a valid/ready input. It drives a single-port RAM interface and issues one-cycle pulses on the paired-operand output.

Top module: `opmatch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tok_ready_o` is 1, `out_valid_o` is 0 and `mem_req_o` is 0.
- R2: A token of kind 3 (special) makes no memory access. It is emitted with `out_valid_o` high in the cycle after the accepting edge, with kind 3, template 0, left = token data and right = 0. Special tokens can be accepted on consecutive cycles.
- R3: Tokens of kind 0, 1 and 2 first read the word at address `tok_seg_i`. The low TW bits of that word's operand field are reported on `out_tmpl_o`.
- R4: The match address is `tok_seg_i + tok_off_i + 1`, taken modulo 2^AW. Equal offsets in different segments therefore use different words.
- R5: A kind-0 (pair) token that finds the presence flag (bit DW of the word) at 0 writes {1, token data} to the match address and produces no output.
- R6: A kind-0 token that finds the presence flag at 1 writes the word back with the flag at 0 and the operand kept. It emits a kind-0 output with left = stored operand and right = token data.
- R7: A kind-1 (immediate) token reads the match-address word, ignores its flag and never writes. It emits kind 1 with left = token data and right = the word's operand field.
- R8: A kind-2 (single-operand) token makes no match-store access. It is emitted after the template read with left = token data and right = 0.
- R9: `out_off_o` equals the offset of the token being emitted.
- R10: `tok_ready_o` is 1 only when the unit is idle, and the unit then makes no memory access. The output appears 1, 3 and 4 edges after the accepting edge for kinds 3, 2 and 0/1 respectively. The match-store write of a pair token occurs in the cycle after the second edge following acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token present |
| tok_ready_o | output | 1 | Unit idle, token taken at this edge |
| tok_kind_i | input | 2 | 0 pair, 1 immediate, 2 single, 3 special |
| tok_seg_i | input | AW | Operand-segment base address |
| tok_off_i | input | OW | Node offset within the segment |
| tok_data_i | input | DW | Operand value |
| mem_req_o | output | 1 | Matching-store access |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW+1 | Write word, flag in bit DW |
| mem_rdata_i | input | DW+1 | Read word, valid one cycle after the read |
| out_valid_o | output | 1 | Output pulse |
| out_kind_o | output | 2 | Kind of the emitted token |
| out_tmpl_o | output | TW | Template-segment number |
| out_off_o | output | OW | Instruction offset within the template |
| out_left_o | output | DW | Left operand |
| out_right_o | output | DW | Right operand |

## Verification
The bench builds the unit with its defaults: DW=32, AW=10, OW=6 and TW=8. This gives a 1024-word store in which several segments can share one offset. The largest offset, 63, lands 64 words above its base, so the boundary of the offset field falls inside a segment that is clear of the others. The 32-bit operand lets a template word carry bits above the TW-bit field. This shows that only the low bits reach the template output. Stored words with the flag set or cleared exercise both branches of pairing and show that immediate reads ignore the flag.

// File: rtl/opm_pkg.sv
package opm_pkg;
  typedef enum logic [1:0] {
    K_PAIR    = 2'd0,
    K_IMM     = 2'd1,
    K_SINGLE  = 2'd2,
    K_SPECIAL = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TNF  = 2'd1,
    ST_MRD  = 2'd2,
    ST_MEV  = 2'd3
  } opm_state_e;
endpackage

// File: rtl/opm_ctrl.sv
module opm_ctrl
  import opm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tok_valid_i,
  input  tok_kind_e  kind_i,
  input  tok_kind_e  kind_q_i,
  output opm_state_e state_o,
  output logic       accept_o
);
  opm_state_e state_q, state_d;

  assign accept_o = tok_valid_i && (state_q == ST_IDLE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o && kind_i != K_SPECIAL) state_d = ST_TNF;
      ST_TNF:  state_d = ST_MRD;
      ST_MRD:  state_d = (kind_q_i == K_SINGLE) ? ST_IDLE : ST_MEV;
      ST_MEV:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/opm_port.sv
module opm_port
  import opm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int OW = 6
) (
  input  opm_state_e      state_i,
  input  tok_kind_e       kind_q_i,
  input  logic [AW-1:0]   seg_q_i,
  input  logic [OW-1:0]   off_q_i,
  input  logic [DW-1:0]   data_q_i,
  input  logic [DW:0]     rdata_i,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW:0]     wdata_o,
  output logic            hit_o
);
  localparam int FLAG = DW;
  logic [AW-1:0] match_addr;

  // slot 0 of a segment holds the template number
  assign match_addr = seg_q_i + AW'(off_q_i) + AW'(1);
  assign hit_o      = rdata_i[FLAG];

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = seg_q_i;
    wdata_o = '0;
    unique case (state_i)
      ST_TNF: req_o = 1'b1;
      ST_MRD: begin
        if (kind_q_i != K_SINGLE) begin
          req_o  = 1'b1;
          addr_o = match_addr;
        end
      end
      ST_MEV: begin
        if (kind_q_i == K_PAIR) begin
          req_o   = 1'b1;
          we_o    = 1'b1;
          addr_o  = match_addr;
          wdata_o = hit_o ? {1'b0, rdata_i[DW-1:0]} : {1'b1, data_q_i};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opm_out.sv
module opm_out #(
  parameter int DW = 32,
  parameter int OW = 6,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          emit_i,
  input  logic [1:0]    kind_i,
  input  logic [TW-1:0] tmpl_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic          valid_o,
  output logic [1:0]    kind_o,
  output logic [TW-1:0] tmpl_o,
  output logic [OW-1:0] off_o,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= '0;
      tmpl_o  <= '0;
      off_o   <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) begin
        kind_o  <= kind_i;
        tmpl_o  <= tmpl_i;
        off_o   <= off_i;
        left_o  <= left_i;
        right_o <= right_i;
      end
    end
  end
endmodule

// File: rtl/opmatch_unit.sv
module opmatch_unit
  import opm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int OW = 6,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_valid_i,
  output logic          tok_ready_o,
  input  logic [1:0]    tok_kind_i,
  input  logic [AW-1:0] tok_seg_i,
  input  logic [OW-1:0] tok_off_i,
  input  logic [DW-1:0] tok_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW:0]   mem_wdata_o,
  input  logic [DW:0]   mem_rdata_i,
  output logic          out_valid_o,
  output logic [1:0]    out_kind_o,
  output logic [TW-1:0] out_tmpl_o,
  output logic [OW-1:0] out_off_o,
  output logic [DW-1:0] out_left_o,
  output logic [DW-1:0] out_right_o
);
  tok_kind_e     kind_in, kind_q;
  opm_state_e    state;
  logic          accept, hit, emit;
  logic [AW-1:0] seg_q;
  logic [OW-1:0] off_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] tmpl_q;
  logic [1:0]    e_kind;
  logic [TW-1:0] e_tmpl;
  logic [OW-1:0] e_off;
  logic [DW-1:0] e_left, e_right;

  assign kind_in     = tok_kind_e'(tok_kind_i);
  assign tok_ready_o = (state == ST_IDLE);

  opm_ctrl u_ctrl (
    .clk_i, .rst_ni, .tok_valid_i,
    .kind_i(kind_in), .kind_q_i(kind_q),
    .state_o(state), .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_PAIR;
      seg_q  <= '0;
      off_q  <= '0;
      data_q <= '0;
      tmpl_q <= '0;
    end else begin
      if (accept) begin
        kind_q <= kind_in;
        seg_q  <= tok_seg_i;
        off_q  <= tok_off_i;
        data_q <= tok_data_i;
      end
      if (state == ST_MRD) tmpl_q <= mem_rdata_i[TW-1:0];
    end
  end

  opm_port #(.DW(DW), .AW(AW), .OW(OW)) u_port (
    .state_i(state), .kind_q_i(kind_q), .seg_q_i(seg_q), .off_q_i(off_q),
    .data_q_i(data_q), .rdata_i(mem_rdata_i),
    .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .hit_o(hit)
  );

  always_comb begin
    emit    = 1'b0;
    e_kind  = kind_q;
    e_tmpl  = tmpl_q;
    e_off   = off_q;
    e_left  = data_q;
    e_right = '0;
    if (accept && kind_in == K_SPECIAL) begin
      emit   = 1'b1;
      e_kind = K_SPECIAL;
      e_tmpl = '0;
      e_off  = tok_off_i;
      e_left = tok_data_i;
    end else if (state == ST_MRD && kind_q == K_SINGLE) begin
      emit   = 1'b1;
      e_tmpl = mem_rdata_i[TW-1:0];
    end else if (state == ST_MEV && kind_q == K_IMM) begin
      emit    = 1'b1;
      e_right = mem_rdata_i[DW-1:0];
    end else if (state == ST_MEV && kind_q == K_PAIR && hit) begin
      emit    = 1'b1;
      e_left  = mem_rdata_i[DW-1:0];
      e_right = data_q;
    end
  end

  opm_out #(.DW(DW), .OW(OW), .TW(TW)) u_out (
    .clk_i, .rst_ni, .emit_i(emit),
    .kind_i(e_kind), .tmpl_i(e_tmpl), .off_i(e_off),
    .left_i(e_left), .right_i(e_right),
    .valid_o(out_valid_o), .kind_o(out_kind_o), .tmpl_o(out_tmpl_o),
    .off_o(out_off_o), .left_o(out_left_o), .right_o(out_right_o)
  );

  p_special_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_kind_o == 2'd3) |->
      $past(tok_valid_i && tok_ready_o && tok_kind_i == 2'd3));

  p_tmpl_read_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_MRD) |-> $past(mem_req_o && !mem_we_o && mem_addr_o == seg_q));

  p_write_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_req_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o)));

  p_set_is_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_wdata_o[DW]) |=> !out_valid_o);

  p_clear_emits_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_wdata_o[DW]) |=> (out_valid_o && out_kind_o == 2'd0));

  p_imm_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_kind_o == 2'd1) |-> !$past(mem_we_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_ready_o |-> !mem_req_o);
endmodule

// File: tb/opmatch_unit_tb.sv
`timescale 1ns/1ps
module opmatch_unit_tb;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int OW = 6;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          tok_valid = 1'b0, tok_ready;
  logic [1:0]    tok_kind = '0;
  logic [AW-1:0] tok_seg = '0;
  logic [OW-1:0] tok_off = '0;
  logic [DW-1:0] tok_data = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW:0]   mem_wdata, mem_rdata;
  logic          out_valid;
  logic [1:0]    out_kind;
  logic [TW-1:0] out_tmpl;
  logic [OW-1:0] out_off;
  logic [DW-1:0] out_left, out_right;

  opmatch_unit #(.DW(DW), .AW(AW), .OW(OW), .TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_valid_i(tok_valid), .tok_ready_o(tok_ready), .tok_kind_i(tok_kind),
    .tok_seg_i(tok_seg), .tok_off_i(tok_off), .tok_data_i(tok_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_kind_o(out_kind), .out_tmpl_o(out_tmpl),
    .out_off_o(out_off), .out_left_o(out_left), .out_right_o(out_right)
  );

  logic [DW:0] ram     [0:(1<<AW)-1];
  logic [DW:0] exp_mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    mem_rdata <= mem_rdata;
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0, n_req = 0;
  bit run_chk = 1'b0, done = 1'b0;

  typedef struct {
    int due; logic [1:0] kind; logic [TW-1:0] tmpl; logic [OW-1:0] off;
    logic [DW-1:0] l; logic [DW-1:0] r; string tag;
  } out_t;
  typedef struct { int due; logic [AW-1:0] a; logic [DW:0] d; string tag; } wr_t;
  out_t oq[$];
  wr_t  wq[$];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      if (mem_req) n_req++;
      if (out_valid) begin
        if (oq.size() == 0) chk(1'b0, "R10", "unexpected output", 1, 0);
        else begin
          out_t e;
          e = oq.pop_front();
          chk(e.due == cyc, e.tag, "output cycle R10", 64'(cyc), 64'(e.due));
          chk(out_kind == e.kind, e.tag, "kind", 64'(out_kind), 64'(e.kind));
          chk(out_tmpl == e.tmpl, e.tag, "template R3", 64'(out_tmpl), 64'(e.tmpl));
          chk(out_off == e.off, e.tag, "offset R9", 64'(out_off), 64'(e.off));
          chk(out_left == e.l, e.tag, "left", 64'(out_left), 64'(e.l));
          chk(out_right == e.r, e.tag, "right", 64'(out_right), 64'(e.r));
        end
      end else if (oq.size() > 0 && oq[0].due <= cyc) begin
        chk(1'b0, oq[0].tag, "missing output R10", 0, 1);
        void'(oq.pop_front());
      end
      if (mem_req && mem_we) begin
        if (wq.size() == 0) chk(1'b0, "R7", "unexpected write", 64'(mem_addr), 0);
        else begin
          wr_t w;
          w = wq.pop_front();
          chk(w.due == cyc, w.tag, "write cycle R10", 64'(cyc), 64'(w.due));
          chk(mem_addr == w.a, w.tag, "write addr R4", 64'(mem_addr), 64'(w.a));
          chk(mem_wdata == w.d, w.tag, "write data", 64'(mem_wdata), 64'(w.d));
        end
      end else if (wq.size() > 0 && wq[0].due <= cyc) begin
        chk(1'b0, wq[0].tag, "missing write", 0, 1);
        void'(wq.pop_front());
      end
    end
  end

  task automatic send(logic [1:0] k, logic [AW-1:0] seg, logic [OW-1:0] off,
                      logic [DW-1:0] d, string tag);
    int acc;
    logic [AW-1:0] ma;
    logic [TW-1:0] tn;
    logic [DW:0] w;
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = k; tok_seg = seg; tok_off = off; tok_data = d;
    while (!tok_ready) @(negedge clk);
    acc = cyc + 1;
    ma  = seg + AW'(off) + AW'(1);
    tn  = exp_mem[seg][TW-1:0];
    w   = exp_mem[ma];
    case (k)
      2'd3: oq.push_back('{acc, 2'd3, '0, off, d, '0, tag});
      2'd2: oq.push_back('{acc + 2, 2'd2, tn, off, d, '0, tag});
      2'd1: oq.push_back('{acc + 3, 2'd1, tn, off, d, w[DW-1:0], tag});
      default: begin
        if (w[DW]) begin
          oq.push_back('{acc + 3, 2'd0, tn, off, w[DW-1:0], d, tag});
          wq.push_back('{acc + 2, ma, {1'b0, w[DW-1:0]}, tag});
          exp_mem[ma] = {1'b0, w[DW-1:0]};
        end else begin
          wq.push_back('{acc + 2, ma, {1'b1, d}, tag});
          exp_mem[ma] = {1'b1, d};
        end
      end
    endcase
    @(posedge clk);
  endtask

  task automatic gap(int n);
    @(negedge clk);
    tok_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic preload(logic [AW-1:0] a, logic [DW:0] v);
    ram[a] = v;
    exp_mem[a] = v;
  endtask

  localparam logic [AW-1:0] SEG_A = 10'h040;
  localparam logic [AW-1:0] SEG_B = 10'h100;
  localparam logic [AW-1:0] SEG_C = 10'h3B0;

  initial begin
    int req0, bad;
    for (int i = 0; i < (1 << AW); i++) begin ram[i] = '0; exp_mem[i] = '0; end
    preload(SEG_A, {1'b0, 32'h0000_005A});
    preload(SEG_B, {1'b0, 32'h0001_23C3});
    preload(SEG_C, {1'b0, 32'hFFFF_FF11});
    repeat (3) @(negedge clk);
    chk(tok_ready && !out_valid && !mem_req, "R1", "state in reset",
        {tok_ready, out_valid, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tok_ready && !out_valid && !mem_req, "R1", "state after reset",
        {tok_ready, out_valid, mem_req}, 3'b100);
    run_chk = 1'b1;

    // R2: back-to-back special tokens touch no memory
    req0 = n_req;
    send(2'd3, SEG_A, 6'd1, 32'hA000_0001, "R2");
    send(2'd3, SEG_B, 6'd2, 32'hA000_0002, "R2");
    send(2'd3, SEG_C, 6'd3, 32'hA000_0003, "R2");
    send(2'd3, SEG_A, 6'd63, 32'hA000_0004, "R2");
    gap(3);
    chk(n_req == req0, "R2", "memory requests by special tokens", 64'(n_req - req0), 0);

    // R8/R3/R9: single-operand tokens
    send(2'd2, SEG_A, 6'd7, 32'h0000_1111, "R8");
    send(2'd2, SEG_B, 6'd9, 32'h0000_2222, "R3");
    gap(2);

    // R5/R6: pairing on one slot, then reuse after clear
    send(2'd0, SEG_A, 6'd3, 32'h0000_0011, "R5");
    send(2'd0, SEG_A, 6'd3, 32'h0000_0022, "R6");
    send(2'd0, SEG_A, 6'd3, 32'h0000_0033, "R5");
    gap(4);
    send(2'd0, SEG_A, 6'd3, 32'h0000_0044, "R6");

    // R4: same offset, different segments stay separate
    send(2'd0, SEG_A, 6'd5, 32'hAAAA_0005, "R4");
    send(2'd0, SEG_B, 6'd5, 32'hBBBB_0005, "R4");
    send(2'd0, SEG_B, 6'd5, 32'hCCCC_0005, "R4");
    send(2'd0, SEG_A, 6'd5, 32'hDDDD_0005, "R4");

    // R7: immediate partner, flag clear and flag set, word untouched
    preload(SEG_A + 10'd11, {1'b0, 32'h0000_0777});
    preload(SEG_B + 10'd21, {1'b1, 32'h0BAD_F00D});
    send(2'd1, SEG_A, 6'd10, 32'h0000_0100, "R7");
    send(2'd1, SEG_A, 6'd10, 32'h0000_0200, "R7");
    send(2'd1, SEG_B, 6'd20, 32'h0000_0300, "R7");

    // R4 boundary: largest offset
    send(2'd0, SEG_C, 6'd63, 32'h1234_5678, "R4");
    send(2'd3, SEG_C, 6'd63, 32'h5555_5555, "R2");
    send(2'd0, SEG_C, 6'd63, 32'h8765_4321, "R6");
    send(2'd2, SEG_C, 6'd63, 32'h0000_0063, "R8");
    gap(8);

    chk(oq.size() == 0 && wq.size() == 0, "R10", "outstanding expectations",
        64'(oq.size() + wq.size()), 0);
    bad = 0;
    for (int i = 0; i < (1 << AW); i++) if (ram[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R7", "match store contents mismatches", 64'(bad), 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    finish_up();
  end
endmodule